// File: doc/BRIEF.md
# Handshaked DMA Transfer Engine

This engine carries out one DMA channel job at a time. A job is loaded with a start pulse together with a command word, a source address, a destination address and an item count. The engine then moves the data through a single-beat memory master port. Each burst first reads one to four items from the source into a small local buffer, then writes them to the destination. Items are 8, 16 or 32 bits wide. Each side's address either stays fixed or advances by a step after every item.

Either side can be tied to one of fifteen peripheral request lines. Before every burst, the engine checks the selected lines. If a selected line is low, the engine stops and leaves the job unfinished, so that an outside controller can run it again later. After the source half of a burst, the engine raises the acknowledge for the source line. After the destination half, it raises the acknowledge for the destination line.

Whenever the engine stops, it reports the command word, the addresses and the remaining count for write-back to the channel registers. Register storage and the choice of channel are handled outside this block.

Top module: `hsdma_engine`

## Requirements
- R1: Command bit 3 set gives bursts of 4 items, clear gives 1 item. When fewer items remain than the burst length, the final burst moves only the items that remain.
- R2: Command bits 21:20 set the item width for both sides: code 0 is 32 bits, code 1 is 16 bits, codes 2 and 3 are 8 bits.
- R3: Command bits 9:8 set the source step and bits 13:12 the destination step. Code 0 keeps the address fixed, so every item of a burst uses the same address. Codes 1, 2 and 3 add 1, 2 or 4 item sizes (in bytes) after each item.
- R4: Command bits 27:24 name the source request line and bits 19:16 the destination request line. An ID of 0 means that side does not wait, and its acknowledge is never raised.
- R5: If a named request line is low when a burst is due, the engine stops without any memory access. It reports start bit 0 still set, and the count and addresses as they were at that point.
- R6: The source acknowledge rises after the last read of a burst, and the destination acknowledge after the last write.
- R7: An acknowledge falls in the cycle after its request input falls. Reset clears all acknowledges.
- R8: The count drops by the number of items in each burst. On every stop, the current source address, destination address and count are presented on the write-back outputs while done is high.
- R9: On completion (count zero), write-back start bit 0 is cleared and finish bit 1 is set only when enable bit 2 is set. A job loaded with count zero completes at once.
- R10: Each access drives byte enables that match the item width, shifted by the low address bits. Items are taken from and placed on the matching byte lanes.
- R11: A memory request holds its address, direction and data until a cycle with ready high.
- R12: After reset the engine is idle, with no request, no done and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load a job (ignored while busy) |
| cmd_i | input | 32 | Command word of the job |
| src_i | input | AW | Source address of the job |
| dst_i | input | AW | Destination address of the job |
| count_i | input | CW | Items left in the job |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle stop pulse |
| cmd_o | output | 32 | Command word to write back |
| src_o | output | AW | Source address to write back |
| dst_o | output | AW | Destination address to write back |
| count_o | output | CW | Item count to write back |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Access address |
| mem_be_o | output | DW/8 | Byte enables |
| mem_wdata_o | output | DW | Write data |
| mem_rdy_i | input | 1 | Access accepted (read data valid) |
| mem_rdata_i | input | DW | Read data |
| hs_req_i | input | NHS | Peripheral request lines (bit 0 unused) |
| hs_ack_o | output | NHS | Peripheral acknowledge lines |

## Verification
The assertions assume a few things about the inputs. Ready may come in any cycle, and read data is valid in the same cycle that ready is high. Addresses are aligned to the item size. Request lines change only between jobs. The stimulus follows these rules: it randomizes ready on every cycle, aligns every random address to its width, and changes request lines only while the engine is idle, pulsing them low to clear the acknowledges before each random job.

// File: rtl/hsdma_pkg.sv
package hsdma_pkg;
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_READ, S_WRITE, S_DONE} hsdma_st_e;

  localparam int unsigned BIT_START = 0;
  localparam int unsigned BIT_FIN   = 1;
  localparam int unsigned BIT_FINEN = 2;
  localparam int unsigned BIT_BURST = 3;

  // log2 of item size in bytes from the width code
  function automatic logic [1:0] size_log2(input logic [1:0] wcode);
    case (wcode)
      2'd0:    size_log2 = 2'd2;
      2'd1:    size_log2 = 2'd1;
      default: size_log2 = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/hsdma_decode.sv
module hsdma_decode
  import hsdma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDW  = 4,
  parameter int MAXB = 4,
  parameter int BW   = 3
) (
  input  logic [31:0]    cmd_i,
  output logic [BW-1:0]  blen_o,
  output logic [1:0]     sz_o,
  output logic [AW-1:0]  sstep_o,
  output logic [AW-1:0]  dstep_o,
  output logic [IDW-1:0] sid_o,
  output logic [IDW-1:0] did_o,
  output logic           fin_en_o
);
  logic [1:0] sz;

  assign sz       = size_log2(cmd_i[21:20]);
  assign sz_o     = sz;
  assign blen_o   = cmd_i[BIT_BURST] ? BW'(MAXB) : BW'(1);
  assign sid_o    = cmd_i[24 +: IDW];
  assign did_o    = cmd_i[16 +: IDW];
  assign fin_en_o = cmd_i[BIT_FINEN];

  always_comb begin
    sstep_o = (cmd_i[9:8] == 2'd0) ? '0 : AW'(1) << (32'(cmd_i[9:8]) - 1 + 32'(sz));
    dstep_o = (cmd_i[13:12] == 2'd0) ? '0 : AW'(1) << (32'(cmd_i[13:12]) - 1 + 32'(sz));
  end
endmodule

// File: rtl/hsdma_lane.sv
module hsdma_lane #(
  parameter  int DW = 32,
  localparam int NB = DW / 8,
  localparam int LB = $clog2(NB)
) (
  input  logic [DW-1:0] rdata_i,
  input  logic [LB-1:0] lo_i,
  input  logic [1:0]    sz_i,
  input  logic [DW-1:0] item_i,
  output logic [DW-1:0] item_o,
  output logic [NB-1:0] be_o,
  output logic [DW-1:0] wdata_o
);
  logic [NB-1:0] bmask;
  logic [DW-1:0] dmask;
  logic [31:0]   nbytes;

  always_comb begin
    nbytes  = 32'd1 << sz_i;
    // full-width case wraps to zero, minus one gives all ones
    bmask   = (NB'(1) << nbytes) - NB'(1);
    dmask   = (DW'(1) << (nbytes * 8)) - DW'(1);
    be_o    = bmask << lo_i;
    item_o  = (rdata_i >> (32'(lo_i) * 8)) & dmask;
    wdata_o = (item_i & dmask) << (32'(lo_i) * 8);
  end
endmodule

// File: rtl/hsdma_ack.sv
module hsdma_ack #(
  parameter int NHS = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NHS-1:0] req_i,
  input  logic [NHS-1:0] set_i,
  output logic [NHS-1:0] ack_o
);
  logic [NHS-1:0] req_prev_q, ack_q, ack_d, fall;

  assign fall  = req_prev_q & ~req_i;
  assign ack_d = (ack_q & ~fall) | set_i;
  assign ack_o = ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= '0;
      ack_q      <= '0;
    end else begin
      req_prev_q <= req_i;
      ack_q      <= ack_d;
    end
  end

  for (genvar g = 0; g < NHS; g++) begin : g_chk
    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_prev_q[g] && !req_i[g] && !set_i[g]) |=> !ack_o[g]);
  end
endmodule

// File: rtl/hsdma_engine.sv
module hsdma_engine
  import hsdma_pkg::*;
#(
  parameter  int AW   = 32,
  parameter  int DW   = 32,
  parameter  int CW   = 24,
  parameter  int NHS  = 16,
  parameter  int MAXB = 4,
  localparam int NB   = DW / 8,
  localparam int LB   = $clog2(NB),
  localparam int IDW  = $clog2(NHS),
  localparam int BW   = $clog2(MAXB + 1),
  localparam int XW   = $clog2(MAXB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [31:0]    cmd_i,
  input  logic [AW-1:0]  src_i,
  input  logic [AW-1:0]  dst_i,
  input  logic [CW-1:0]  count_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [31:0]    cmd_o,
  output logic [AW-1:0]  src_o,
  output logic [AW-1:0]  dst_o,
  output logic [CW-1:0]  count_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [NB-1:0]  mem_be_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic           mem_rdy_i,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic [NHS-1:0] hs_req_i,
  output logic [NHS-1:0] hs_ack_o
);
  hsdma_st_e      st_q, st_d;
  logic [31:0]    cmd_q, cmd_d;
  logic [AW-1:0]  src_q, src_d, dst_q, dst_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [XW-1:0]  idx_q, idx_d;
  logic [BW-1:0]  nb_q, nb_d;
  logic [DW-1:0]  buf_q [MAXB];
  logic           buf_we;
  logic [NHS-1:0] ack_set;

  logic [BW-1:0]  blen;
  logic [1:0]     sz;
  logic [AW-1:0]  sstep, dstep;
  logic [IDW-1:0] sid, did;
  logic           fin_en, stall, last;
  logic [DW-1:0]  item_rd;

  hsdma_decode #(.AW(AW), .IDW(IDW), .MAXB(MAXB), .BW(BW)) u_dec (
    .cmd_i(cmd_q), .blen_o(blen), .sz_o(sz), .sstep_o(sstep), .dstep_o(dstep),
    .sid_o(sid), .did_o(did), .fin_en_o(fin_en)
  );

  hsdma_lane #(.DW(DW)) u_lane (
    .rdata_i(mem_rdata_i), .lo_i(mem_addr_o[LB-1:0]), .sz_i(sz),
    .item_i(buf_q[idx_q]), .item_o(item_rd), .be_o(mem_be_o), .wdata_o(mem_wdata_o)
  );

  hsdma_ack #(.NHS(NHS)) u_ack (
    .clk(clk), .rst_n(rst_n), .req_i(hs_req_i), .set_i(ack_set), .ack_o(hs_ack_o)
  );

  assign stall = ((sid != '0) && !hs_req_i[sid]) || ((did != '0) && !hs_req_i[did]);
  assign last  = (BW'(idx_q) + BW'(1)) == nb_q;

  always_comb begin
    st_d    = st_q;
    cmd_d   = cmd_q;
    src_d   = src_q;
    dst_d   = dst_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    nb_d    = nb_q;
    buf_we  = 1'b0;
    ack_set = '0;
    case (st_q)
      S_IDLE: if (start_i) begin
        cmd_d = cmd_i;
        src_d = src_i;
        dst_d = dst_i;
        cnt_d = count_i;
        st_d  = S_CHECK;
      end
      S_CHECK: begin
        if (cnt_q == '0) begin
          cmd_d[BIT_START] = 1'b0;
          if (fin_en) cmd_d[BIT_FIN] = 1'b1;
          st_d = S_DONE;
        end else if (stall) begin
          st_d = S_DONE;
        end else begin
          nb_d  = (cnt_q < CW'(blen)) ? BW'(cnt_q) : blen;
          idx_d = '0;
          st_d  = S_READ;
        end
      end
      S_READ: if (mem_rdy_i) begin
        buf_we = 1'b1;
        src_d  = src_q + sstep;
        if (last) begin
          idx_d = '0;
          st_d  = S_WRITE;
          if (sid != '0) ack_set[sid] = 1'b1;
        end else begin
          idx_d = idx_q + XW'(1);
        end
      end
      S_WRITE: if (mem_rdy_i) begin
        dst_d = dst_q + dstep;
        if (last) begin
          cnt_d = cnt_q - CW'(nb_q);
          st_d  = S_CHECK;
          if (did != '0) ack_set[did] = 1'b1;
        end else begin
          idx_d = idx_q + XW'(1);
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cmd_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      idx_q <= '0;
      nb_q  <= '0;
      for (int i = 0; i < MAXB; i++) buf_q[i] <= '0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      nb_q  <= nb_d;
      if (buf_we) buf_q[idx_q] <= item_rd;
    end
  end

  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_DONE);
  assign cmd_o      = cmd_q;
  assign src_o      = src_q;
  assign dst_o      = dst_q;
  assign count_o    = cnt_q;
  assign mem_req_o  = (st_q == S_READ) || (st_q == S_WRITE);
  assign mem_we_o   = (st_q == S_WRITE);
  assign mem_addr_o = (st_q == S_WRITE) ? dst_q : src_q;

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_wdata_o)));
  // R10
  be_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ($countones(mem_be_o) == (32'd1 << sz)));
  // R5
  stall_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CHECK && cnt_q != '0 && stall) |=> (done_o && cmd_o[BIT_START] && $stable(count_o)));
  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && count_o == '0) |-> !cmd_o[BIT_START]);
  // R8
  cnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WRITE && mem_rdy_i && last) |=> (count_o < $past(count_o)));
  // R3
  fixed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_READ && mem_rdy_i && sstep == '0) |=> (src_o == $past(src_o)));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !mem_req_o);
endmodule

// File: tb/hsdma_engine_test.sv
`timescale 1ns/1ps
module hsdma_engine_test;
  logic        clk, rst_n, start_i, mem_rdy;
  logic [31:0] cmd_i, src_i, dst_i;
  logic [23:0] count_i;
  logic        busy_o, done_o, mem_req, mem_we;
  logic [31:0] cmd_o, src_o, dst_o, mem_addr, mem_wdata, mem_rdata;
  logic [23:0] count_o;
  logic [3:0]  mem_be;
  logic [15:0] hs_req, hs_ack;

  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [31:0] e_cmd, e_src, e_dst;
  logic [23:0] e_cnt;
  logic [15:0] e_ack;
  int          tests, fails;

  hsdma_engine uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .src_i(src_i),
    .dst_i(dst_i), .count_i(count_i), .busy_o(busy_o), .done_o(done_o),
    .cmd_o(cmd_o), .src_o(src_o), .dst_o(dst_o), .count_o(count_o),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdy_i(mem_rdy), .mem_rdata_i(mem_rdata),
    .hs_req_i(hs_req), .hs_ack_o(hs_ack)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign mem_rdata = {mem[{mem_addr[7:2], 2'd3}], mem[{mem_addr[7:2], 2'd2}],
                      mem[{mem_addr[7:2], 2'd1}], mem[{mem_addr[7:2], 2'd0}]};

  always @(posedge clk)
    if (mem_req && mem_we && mem_rdy)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[{mem_addr[7:2], 2'(b)}] <= mem_wdata[8*b +: 8];

  always @(negedge clk) mem_rdy <= ($urandom % 4) != 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcmd(input bit b4, input logic [1:0] w, ss, ds,
                                        input logic [3:0] si, di, input bit fe);
    mkcmd = 32'd1 | (32'(fe) << 2) | (32'(b4) << 3) | (32'(ss) << 8) | (32'(ds) << 12)
          | (32'(di) << 16) | (32'(w) << 20) | (32'(si) << 24);
  endfunction

  // independent model of one engine run from the requirements
  task automatic model(input logic [31:0] c, s, d, input logic [23:0] n);
    int bl, sz, ss, ds, nb;
    logic [3:0] si, di;
    logic [7:0] tmp [16];
    bit go;
    bl = c[3] ? 4 : 1;
    sz = (c[21:20] == 2'd0) ? 4 : (c[21:20] == 2'd1) ? 2 : 1;
    ss = (c[9:8] == 2'd0) ? 0 : (1 << (int'(c[9:8]) - 1)) * sz;
    ds = (c[13:12] == 2'd0) ? 0 : (1 << (int'(c[13:12]) - 1)) * sz;
    si = c[27:24];
    di = c[19:16];
    e_ack = '0;
    go = 1;
    while (go) begin
      if (n == 0) begin
        c[0] = 1'b0;
        if (c[2]) c[1] = 1'b1;
        go = 0;
      end else if ((si != 0 && !hs_req[si]) || (di != 0 && !hs_req[di])) begin
        go = 0;
      end else begin
        nb = (int'(n) < bl) ? int'(n) : bl;
        for (int i = 0; i < nb; i++) begin
          for (int k = 0; k < sz; k++) tmp[i*4+k] = exp_mem[8'(s + 32'(k))];
          s = s + 32'(ss);
        end
        if (si != 0) e_ack[si] = 1'b1;
        for (int i = 0; i < nb; i++) begin
          for (int k = 0; k < sz; k++) exp_mem[8'(d + 32'(k))] = tmp[i*4+k];
          d = d + 32'(ds);
        end
        if (di != 0) e_ack[di] = 1'b1;
        n = n - 24'(nb);
      end
    end
    e_cmd = c; e_src = s; e_dst = d; e_cnt = n;
  endtask

  task automatic run_job(input logic [31:0] c, s, d, input logic [23:0] n, input string tag);
    int bad;
    model(c, s, d, n);
    @(negedge clk);
    cmd_i = c; src_i = s; dst_i = d; count_i = n; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk({tag, " R9 cmd"}, cmd_o, e_cmd);
    chk({tag, " R8 src"}, src_o, e_src);
    chk({tag, " R8 dst"}, dst_o, e_dst);
    chk({tag, " R8 count"}, 32'(count_o), 32'(e_cnt));
    chk({tag, " R6 ack"}, 32'(hs_ack), 32'(e_ack));
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk({tag, " R10 R11 memory mismatches"}, 32'(bad), 32'd0);
  endtask

  task automatic clear_acks(input logic [15:0] after);
    @(negedge clk); hs_req = '0;
    repeat (2) @(negedge clk);
    hs_req = after;
    @(negedge clk);
  endtask

  initial begin
    tests = 0; fails = 0;
    void'($urandom(32'd4021));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom);
      exp_mem[i] = mem[i];
    end
    rst_n = 1'b0; start_i = 1'b0; cmd_i = '0; src_i = '0; dst_i = '0; count_i = '0;
    hs_req = 16'hFFFE;
    repeat (3) @(negedge clk);
    // R12 reset state, R7 acks cleared by reset
    chk("R12 busy", 32'(busy_o), 0);
    chk("R12 done", 32'(done_o), 0);
    chk("R12 mem_req", 32'(mem_req), 0);
    chk("R7 reset ack", 32'(hs_ack), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3: 8-bit, fixed source, burst 4 with short final burst
    run_job(mkcmd(1, 2'd2, 2'd0, 2'd1, 4'd0, 4'd0, 1), 32'h11, 32'h81, 24'd6, "R1 R3 fixed");
    // R2: 16-bit items, step code 3 on both sides
    run_job(mkcmd(1, 2'd1, 2'd3, 2'd3, 4'd0, 4'd0, 1), 32'h22, 32'hA6, 24'd5, "R2 16b");
    // R9: finish enable off
    run_job(mkcmd(0, 2'd0, 2'd1, 2'd2, 4'd0, 4'd0, 0), 32'h40, 32'hC0, 24'd3, "R9 no fin");
    // R9: count zero completes at once
    run_job(mkcmd(1, 2'd0, 2'd1, 2'd1, 4'd0, 4'd0, 1), 32'h40, 32'hC0, 24'd0, "R9 zero");
    // R4: no handshake IDs, every request line low
    clear_acks(16'h0000);
    run_job(mkcmd(1, 2'd0, 2'd1, 2'd1, 4'd0, 4'd0, 1), 32'h10, 32'hE0, 24'd4, "R4 no hs");
    // R5: source line 3 low, engine stops with nothing moved
    clear_acks(16'hFFF6);
    run_job(mkcmd(1, 2'd2, 2'd1, 2'd1, 4'd3, 4'd5, 1), 32'h05, 32'h95, 24'd7, "R5 stall");
    chk("R5 start kept", 32'(cmd_o[0]), 1);
    @(negedge clk); hs_req = 16'hFFFE; @(negedge clk);
    // R5 rerun from write-back, R6 acks on lines 3 and 5
    run_job(cmd_o, src_o, dst_o, count_o, "R5 resume");
    chk("R6 ack3", 32'(hs_ack[3]), 1);
    chk("R6 ack5", 32'(hs_ack[5]), 1);
    // R7: lowering request 3 drops only acknowledge 3
    @(negedge clk); hs_req[3] = 1'b0;
    @(negedge clk);
    chk("R7 ack3 low", 32'(hs_ack[3]), 0);
    chk("R7 ack5 kept", 32'(hs_ack[5]), 1);
    @(negedge clk); hs_req[3] = 1'b1;

    // random jobs
    for (int j = 0; j < 40; j++) begin
      logic [1:0] w, ss, ds;
      logic [3:0] si, di;
      logic [31:0] s, d;
      int sz;
      w  = 2'($urandom); ss = 2'($urandom); ds = 2'($urandom);
      si = ($urandom % 3 == 0) ? 4'd0 : 4'(1 + $urandom % 15);
      di = ($urandom % 3 == 0) ? 4'd0 : 4'(1 + $urandom % 15);
      sz = (w == 2'd0) ? 4 : (w == 2'd1) ? 2 : 1;
      s  = $urandom & ~32'(sz - 1);
      d  = $urandom & ~32'(sz - 1);
      clear_acks(16'hFFFE);
      run_job(mkcmd(1'($urandom), w, ss, ds, si, di, 1'($urandom)), s, d,
              24'($urandom % 10), "R1 R2 R3 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule